// File: doc/BRIEF.md
# Clock Source Selection Controller

This block holds the 8-bit clock control and status register of a low-power controller. Software picks the machine clock from three sources: the main oscillator, a PLL output, or a slow subclock. Two writable select bits carry the request. Two read-only status bits report which source actually drives the machine clock.

A status bit follows its select bit only after an oscillator stabilization wait, counted in oscillator ticks. Moving from the subclock to the main clock waits for a length chosen by a 2-bit wait field. Moving from the main clock to the PLL waits for a fixed length set by a parameter. Moves toward the subclock, and from the PLL back to the main clock, take effect on the next clock. When a main-clock wait starts, the block sends a one-cycle clear pulse to an external timebase timer.

There are two reset inputs. Power-on reset restores the whole register. The other reset (standby, watchdog, external or software) leaves the wait field as it was.

Top module: `clk_src_sel`

## Requirements
- R1: After any reset the register reads 8'hFC: both status bits 1, select bits 1, multiplier field 00, and the wait field 11 after power-on. The source code output reads 01 (main).
- R2: The wait field (bits 5:4) is set to 11 only by `por_n`. A `rst_n` reset leaves it unchanged and still returns both select bits to 1.
- R3: A write loads bits 5:0 (wait field, main/sub select at bit 3, main/PLL select at bit 2, multiplier at bits 1:0). The written values of bits 7:6 are ignored.
- R4: Writing 1 to bit 3 while it is 0 starts the main wait. Bit 7 becomes 1 on the N-th clock edge after the write edge, where N = 1 for wait code 00, 2^WAIT_LOG_A ticks for 01, 2^WAIT_LOG_B for 10 and 2^WAIT_LOG_C for 11. The defaults are 14, 16 and 18.
- R5: The wait counters advance only in cycles where `osc_tick` is 1.
- R6: `tbt_clr` is high for exactly the one cycle after a write that sets bit 3 from 0 to 1. It stays low for any other write.
- R7: Writing 0 to bit 2 while it is 1 starts the PLL wait. Bit 6 stays 1 and falls on the edge that completes 2^PLL_WAIT_LOG ticks (default 2^14), whatever the wait field holds.
- R8: Once bit 3 reads 0, bit 7 drops to 0 on the next edge. Once bit 2 reads 1, bit 6 rises to 1 on the next edge. Neither move has a wait.
- R9: `src` is 00 (subclock) whenever bit 7 is 0, whatever bit 6 holds. It is 01 (main) when bits 7:6 are 11 and 10 (PLL) when they are 10.
- R10: Clearing a select bit during its wait abandons the wait. A later request starts counting again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Other reset sources, active low, asynchronous |
| osc_tick | input | 1 | One-cycle pulse per source-oscillator cycle |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| src | output | 2 | Source driving the machine clock: 00 sub, 01 main, 10 PLL |
| mul_sel | output | 2 | PLL multiplier field |
| tbt_clr | output | 1 | One-cycle clear pulse to the timebase timer |

## Verification
The assertions assume that the wait field is not lowered while a main wait is counting. They also assume that resets are asserted and released away from the active clock edge. The stimulus changes the wait field only while no main wait is active. It drives every input, resets included, on the falling edge. Each timed wait is run with `osc_tick` held high, so that the expected edge can be counted exactly. One run holds `osc_tick` low for a stretch to show that the count stalls.

// File: rtl/clk_src_sel.sv
module clk_src_sel #(
  parameter int WAIT_LOG_A   = 14,
  parameter int WAIT_LOG_B   = 16,
  parameter int WAIT_LOG_C   = 18,
  parameter int PLL_WAIT_LOG = 14
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [1:0] src,
  output logic [1:0] mul_sel,
  output logic       tbt_clr
);

  localparam int CW  = WAIT_LOG_C + 1;
  localparam int PCW = PLL_WAIT_LOG + 1;
  localparam logic [CW-1:0]  ONE_M = CW'(1);
  localparam logic [PCW-1:0] P_LAST = PCW'((1 << PLL_WAIT_LOG) - 1);

  logic          any_rst_n;
  logic          stat_ms, stat_mp, sel_ms, sel_mp;
  logic [1:0]    ws;
  logic [CW-1:0] ms_cnt, ms_thr;
  logic [PCW-1:0] p_cnt;
  logic          ms_start, ms_wait, ms_done;
  logic          p_start, p_wait, p_done;

  assign any_rst_n = por_n & rst_n;

  always_comb begin
    case (ws)
      2'b00:   ms_thr = '0;
      2'b01:   ms_thr = ONE_M << WAIT_LOG_A;
      2'b10:   ms_thr = ONE_M << WAIT_LOG_B;
      default: ms_thr = ONE_M << WAIT_LOG_C;
    endcase
  end

  assign ms_start = wr_en & wr_data[3] & ~sel_ms;
  assign ms_wait  = sel_ms & ~stat_ms;
  assign ms_done  = ms_wait & ((ms_thr == '0) | (osc_tick & (ms_cnt == ms_thr - ONE_M)));

  assign p_start  = wr_en & ~wr_data[2] & sel_mp;
  assign p_wait   = ~sel_mp & stat_mp;
  assign p_done   = p_wait & osc_tick & (p_cnt == P_LAST);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)     ws <= 2'b11;
    else if (wr_en) ws <= wr_data[5:4];

  always_ff @(posedge clk or negedge any_rst_n)
    if (!any_rst_n) begin
      sel_ms  <= 1'b1;
      sel_mp  <= 1'b1;
      mul_sel <= 2'b00;
      tbt_clr <= 1'b0;
    end else begin
      if (wr_en) begin
        sel_ms  <= wr_data[3];
        sel_mp  <= wr_data[2];
        mul_sel <= wr_data[1:0];
      end
      tbt_clr <= ms_start;
    end

  always_ff @(posedge clk or negedge any_rst_n)
    if (!any_rst_n) begin
      stat_ms <= 1'b1;
      ms_cnt  <= '0;
    end else begin
      if (ms_start)                ms_cnt <= '0;
      else if (ms_wait && osc_tick) ms_cnt <= ms_cnt + ONE_M;
      if (!sel_ms && stat_ms)      stat_ms <= 1'b0;
      else if (ms_done)            stat_ms <= 1'b1;
    end

  always_ff @(posedge clk or negedge any_rst_n)
    if (!any_rst_n) begin
      stat_mp <= 1'b1;
      p_cnt   <= '0;
    end else begin
      if (p_start)                 p_cnt <= '0;
      else if (p_wait && osc_tick) p_cnt <= p_cnt + PCW'(1);
      if (sel_mp && !stat_mp)      stat_mp <= 1'b1;
      else if (p_done)             stat_mp <= 1'b0;
    end

  assign rd_data = {stat_ms, stat_mp, ws, sel_ms, sel_mp, mul_sel};
  assign src     = !stat_ms ? 2'b00 : (stat_mp ? 2'b01 : 2'b10);

  p_main_rise_r4: assert property (@(posedge clk) disable iff (!any_rst_n)
    $rose(stat_ms) |-> $past(sel_ms));

  p_stall_r5: assert property (@(posedge clk) disable iff (!any_rst_n)
    (sel_ms && !stat_ms && !osc_tick && ws != 2'b00) |=> !stat_ms);

  p_tbt_once_r6: assert property (@(posedge clk) disable iff (!any_rst_n)
    tbt_clr |=> !tbt_clr);

  p_tbt_cause_r6: assert property (@(posedge clk) disable iff (!any_rst_n)
    tbt_clr |-> $rose(sel_ms));

  p_pll_fall_r7: assert property (@(posedge clk) disable iff (!any_rst_n)
    $fell(stat_mp) |-> $past(!sel_mp));

  p_sub_next_r8: assert property (@(posedge clk) disable iff (!any_rst_n)
    (!sel_ms && stat_ms) |=> !stat_ms);

  p_ro_ms_r3: assert property (@(posedge clk) disable iff (!any_rst_n)
    (wr_en && wr_data[7] && !wr_data[3] && !sel_ms && !stat_ms) |=> !stat_ms);

  p_ro_mp_r3: assert property (@(posedge clk) disable iff (!any_rst_n)
    (wr_en && wr_data[6] && !wr_data[2] && !sel_mp && !stat_mp) |=> !stat_mp);

endmodule

// File: tb/test_clk_src_sel.sv
module test_clk_src_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 3, WB = 4, WC = 5, WP = 2;
  localparam int PN = 1 << WP;

  // {write data, expected read value, expected src}
  localparam logic [17:0] VEC [8] = '{
    {8'hF4, 8'h74, 2'b00},
    {8'h01, 8'h01, 2'b00},
    {8'h09, 8'h89, 2'b10},
    {8'h0E, 8'hCE, 2'b01},
    {8'h1B, 8'h9B, 2'b10},
    {8'h53, 8'h13, 2'b00},
    {8'h2F, 8'hEF, 2'b01},
    {8'h3C, 8'hFC, 2'b01}
  };

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b1, osc_tick = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] src, mul_sel;
  logic       tbt_clr;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_sel #(.WAIT_LOG_A(WA), .WAIT_LOG_B(WB), .WAIT_LOG_C(WC), .PLL_WAIT_LOG(WP)) i_clk_src_sel (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .osc_tick(osc_tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .src(src), .mul_sel(mul_sel), .tbt_clr(tbt_clr));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic main_wait(input logic [1:0] w, input int n, input string tag);
    wr({2'b00, w, 4'b0100});
    step(3);
    check({tag, " on sub"}, {7'd0, rd_data[7]}, 8'd0);
    wr({2'b00, w, 4'b1100});
    check("R6 clear pulse", {7'd0, tbt_clr}, 8'd1);
    step(n - 1);
    check({tag, " before end"}, {7'd0, rd_data[7]}, 8'd0);
    step(1);
    check({tag, " at end"}, {7'd0, rd_data[7]}, 8'd1);
  endtask

  task automatic pll_wait(input logic [1:0] w, input string tag);
    wr({2'b00, w, 4'b1100});
    step(40);
    wr({2'b00, w, 4'b1000});
    step(PN - 1);
    check({tag, " before end"}, {6'd0, rd_data[7:6]}, 8'h03);
    check({tag, " src main"}, {6'd0, src}, 8'h01);
    step(1);
    check({tag, " at end"}, {6'd0, rd_data[7:6]}, 8'h02);
    check("R9 src pll", {6'd0, src}, 8'h02);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); step(2);
    por_n = 1'b1;
    step(1);
    check("R1 reset value", rd_data, 8'hFC);
    check("R1 reset src", {6'd0, src}, 8'h01);
    check("R1 no pulse", {7'd0, tbt_clr}, 8'd0);

    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][17:10]);
      step(40);
      check("R3 R8 R9 vector read", rd_data, VEC[v][9:2]);
      check("R9 vector src", {6'd0, src}, {6'd0, VEC[v][1:0]});
      check("R3 vector mul", {6'd0, mul_sel}, {6'd0, VEC[v][17:16] & 2'b00 | VEC[v][11:10]});
    end

    main_wait(2'b00, 1, "R4 ws00");
    main_wait(2'b01, 1 << WA, "R4 ws01");
    main_wait(2'b10, 1 << WB, "R4 ws10");
    main_wait(2'b11, 1 << WC, "R4 ws11");

    // R8: switch to sub takes effect on the next edge
    wr(8'h14);
    check("R8 sub lag", {7'd0, rd_data[7]}, 8'd1);
    step(1);
    check("R8 sub next", {7'd0, rd_data[7]}, 8'd0);

    // R5: stalled count
    osc_tick = 1'b0;
    wr(8'h1C);
    step(20);
    check("R5 stalled", {7'd0, rd_data[7]}, 8'd0);
    osc_tick = 1'b1;
    step((1 << WA) - 1);
    check("R5 resumed before end", {7'd0, rd_data[7]}, 8'd0);
    step(1);
    check("R5 resumed end", {7'd0, rd_data[7]}, 8'd1);

    pll_wait(2'b00, "R7 ws00");
    pll_wait(2'b11, "R7 ws11");

    // R6: no pulse when bit 3 already 1
    wr(8'hFC);
    step(3);
    wr(8'hFC);
    check("R6 no pulse", {7'd0, tbt_clr}, 8'd0);

    // R10: abandon and restart
    wr(8'h14); step(3);
    wr(8'h1C); step(5);
    wr(8'h14);
    check("R10 cancel no pulse", {7'd0, tbt_clr}, 8'd0);
    step(2);
    wr(8'h1C);
    check("R10 restart pulse", {7'd0, tbt_clr}, 8'd1);
    step(1);
    check("R6 pulse one cycle", {7'd0, tbt_clr}, 8'd0);
    step((1 << WA) - 2);
    check("R10 before end", {7'd0, rd_data[7]}, 8'd0);
    step(1);
    check("R10 at end", {7'd0, rd_data[7]}, 8'd1);

    // R2: non-power-on reset keeps the wait field
    wr(8'h14); step(3);
    rst_n = 1'b0; step(1);
    rst_n = 1'b1; step(1);
    check("R2 keep ws", rd_data, 8'hDC);
    por_n = 1'b0; step(1);
    por_n = 1'b1; step(1);
    check("R2 R1 por", rd_data, 8'hFC);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule